// File: doc/BRIEF.md
# Viewport Frame Buffer Address Generator

This block walks a rectangular viewport inside a wider virtual screen stored in memory and issues one read request per half-word of that viewport. Software-side configuration supplies a 21-bit half-word start address, a 7-bit bank that forms the upper address bits, the viewport width in half-words, the number of half-words skipped between the end of one displayed line and the start of the next, and the line count minus one. Requests leave under a valid/ready handshake. At the end of each displayed line the skip is added. After the last half-word of the frame the address returns to the start value and a one-cycle frame-done pulse is raised.

For each frame the block also computes the frame's end address: start plus (width + skip) × line count. It exports this value and checks that the walk actually lands there. Returned 32-bit words pass through a swap stage with independent byte and half-word swap controls. A pixel depth code is decoded into the number of pixels each fetched half-word carries.

The sequencer is a four-state machine:
- IDLE: configuration is sampled every cycle. It moves to SETUP when enable is high.
- SETUP: computes the end address and loads the start address. It moves to FETCH, or back to IDLE when the width is zero.
- FETCH: a request is presented. It moves to DONE on the accepted last half-word.
- DONE: frame-done is high, the address is reloaded and configuration is sampled again. It moves to SETUP when enable is high, otherwise to IDLE.

Top module: `fbaddr_gen`

## Requirements
- R1: After reset, `req_valid`, `frame_done` and `mismatch` are 0.
- R2: The first request of a frame carries `{bank, start}` on `req_addr` (bank in bits 27:21). The bank bits do not change while requests are presented back to back.
- R3: Within a displayed line, each accepted request is followed by a request for the next half-word (address + 1).
- R4: After the last half-word of a line (width half-words), the next request address is the last address + 1 + skip.
- R5: Half-word address arithmetic wraps modulo 2^21 and never alters the bank bits.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` holds its value on the next cycle.
- R7: The cycle after the last half-word of the last line is accepted, `frame_done` is high for exactly one cycle with `req_valid` low. If enable is still high, the next frame starts again from the start address.
- R8: Once the first request of a frame is presented, `end_addr` equals (start + (width + skip) × (lines + 1)) mod 2^21.
- R9: `mismatch` is raised together with `frame_done` only if the address following the frame's last half-word differs from `end_addr`. For a correct walk it stays 0.
- R10: `rd_out` follows `rd_in` = {b3,b2,b1,b0} as follows: no swap gives {b3,b2,b1,b0}; half-word swap alone gives {b1,b0,b3,b2}; byte swap alone gives {b2,b3,b0,b1}; both give {b0,b1,b2,b3}.
- R11: `pix_per_hw` is 2 for depth code 4'b1011 (8 bpp), 1 for code 4'b1100 (16 bpp), and 0 for every other code.
- R12: A width of zero produces no request while enable is high.
- R13: With enable low at the end of a frame, no further request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run frames while high |
| cfg_start | input | 21 | Start half-word address |
| cfg_bank | input | 7 | Fixed upper address bits |
| cfg_width | input | 11 | Half-words shown per line |
| cfg_skip | input | 11 | Half-words skipped between lines |
| cfg_lines | input | 10 | Line count minus one |
| cfg_depth | input | 4 | Pixel depth code |
| req_valid | output | 1 | Read request presented |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 28 | {bank, half-word address} |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| end_addr | output | 21 | Computed frame end address |
| mismatch | output | 1 | Walk did not land on end address |
| pix_per_hw | output | 2 | Pixels per fetched half-word |
| swap_bytes | input | 1 | Swap bytes within each half-word |
| swap_halves | input | 1 | Swap the two half-words |
| rd_in | input | 32 | Returned data word |
| rd_out | output | 32 | Reordered data word |

## Verification
Line-end skip addition and frame wrap happen on the same handshake: the accepted last half-word of the last line. Width-one and single-line configurations make every half-word a line end and collide the two on the shortest walks. Pseudo-random back-pressure stalls the request exactly at that final half-word. Each sweep is judged by the half-word address expected at every acceptance, the frame-done pulse and the cleared mismatch flag that follow it, and a restart at the start address when enable is still high. Start values near 2^21 force the wrap to cross the field boundary in the same cycle.

// File: rtl/fb_pkg.sv
package fb_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SETUP = 2'd1,
        S_FETCH = 2'd2,
        S_DONE  = 2'd3
    } fb_state_t;

    localparam logic [3:0] DEPTH_8BPP  = 4'b1011;
    localparam logic [3:0] DEPTH_16BPP = 4'b1100;

    function automatic logic [1:0] pix_count(input logic [3:0] code);
        logic [1:0] r;
        unique case (code)
            DEPTH_8BPP:  r = 2'd2;
            DEPTH_16BPP: r = 2'd1;
            default:     r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fb_end_calc.sv
module fb_end_calc #(
    parameter int ADDR_W  = 21,
    parameter int WIDTH_W = 11,
    parameter int LINE_W  = 10
) (
    input  logic [ADDR_W-1:0]  start,
    input  logic [WIDTH_W-1:0] width,
    input  logic [WIDTH_W-1:0] skip,
    input  logic [LINE_W-1:0]  lines,
    output logic [ADDR_W-1:0]  end_addr
);
    localparam int STRIDE_W = WIDTH_W + 1;
    localparam int COUNT_W  = LINE_W + 1;
    localparam int PROD_W   = STRIDE_W + COUNT_W;

    logic [STRIDE_W-1:0] stride;
    logic [COUNT_W-1:0]  count;
    logic [PROD_W-1:0]   span;
    logic [ADDR_W-1:0]   span_t;

    always_comb begin
        stride = {1'b0, width} + {1'b0, skip};
        count  = {1'b0, lines} + COUNT_W'(1);
        span   = PROD_W'(stride) * PROD_W'(count);
    end

    generate
        if (PROD_W >= ADDR_W) begin : g_trunc
            assign span_t = span[ADDR_W-1:0];
        end else begin : g_ext
            assign span_t = ADDR_W'(span);
        end
    endgenerate

    assign end_addr = start + span_t;

endmodule

// File: rtl/fb_swap.sv
module fb_swap #(
    parameter int DATA_W = 32
) (
    input  logic              swap_bytes,
    input  logic              swap_halves,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int HW_N = DATA_W / 16;

    logic [DATA_W-1:0] bsw;
    logic [DATA_W-1:0] hsw;

    generate
        for (genvar h = 0; h < HW_N; h++) begin : g_hw
            assign bsw[h*16 +: 8]     = swap_bytes ? din[h*16+8 +: 8] : din[h*16 +: 8];
            assign bsw[h*16+8 +: 8]   = swap_bytes ? din[h*16 +: 8]   : din[h*16+8 +: 8];
            assign hsw[h*16 +: 16]    = swap_halves ? bsw[(HW_N-1-h)*16 +: 16] : bsw[h*16 +: 16];
        end
    endgenerate

    assign dout = hsw;

endmodule

// File: rtl/fb_seq.sv
module fb_seq
    import fb_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int BANK_W  = 7,
    parameter int WIDTH_W = 11,
    parameter int LINE_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [ADDR_W-1:0]  cfg_start,
    input  logic [BANK_W-1:0]  cfg_bank,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic [WIDTH_W-1:0] cfg_skip,
    input  logic [LINE_W-1:0]  cfg_lines,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [BANK_W+ADDR_W-1:0] req_addr,
    output logic               frame_done,
    output logic [ADDR_W-1:0]  end_addr,
    output logic               mismatch
);
    fb_state_t state_q, state_d;

    logic [ADDR_W-1:0]  start_q;
    logic [BANK_W-1:0]  bank_q;
    logic [WIDTH_W-1:0] width_q;
    logic [WIDTH_W-1:0] skip_q;
    logic [LINE_W-1:0]  lines_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  end_q;
    logic [WIDTH_W-1:0] col_q;
    logic [LINE_W-1:0]  line_q;
    logic               mis_q;

    logic [ADDR_W-1:0]  end_calc;
    logic               take;
    logic               line_end;
    logic               frame_end;
    logic [ADDR_W-1:0]  jump_addr;

    fb_end_calc #(
        .ADDR_W (ADDR_W),
        .WIDTH_W(WIDTH_W),
        .LINE_W (LINE_W)
    ) u_end (
        .start   (start_q),
        .width   (width_q),
        .skip    (skip_q),
        .lines   (lines_q),
        .end_addr(end_calc)
    );

    always_comb begin
        take      = (state_q == S_FETCH) && req_ready;
        line_end  = (col_q == width_q - WIDTH_W'(1));
        frame_end = line_end && (line_q == lines_q);
        jump_addr = addr_q + ADDR_W'(1) + ADDR_W'(skip_q);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (enable) state_d = S_SETUP;
            S_SETUP: state_d = (width_q == '0) ? S_IDLE : S_FETCH;
            S_FETCH: if (take && frame_end) state_d = S_DONE;
            S_DONE:  state_d = enable ? S_SETUP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            bank_q  <= '0;
            width_q <= '0;
            skip_q  <= '0;
            lines_q <= '0;
            addr_q  <= '0;
            end_q   <= '0;
            col_q   <= '0;
            line_q  <= '0;
            mis_q   <= 1'b0;
        end else begin
            mis_q <= 1'b0;
            unique case (state_q)
                S_IDLE, S_DONE: begin
                    start_q <= cfg_start;
                    bank_q  <= cfg_bank;
                    width_q <= cfg_width;
                    skip_q  <= cfg_skip;
                    lines_q <= cfg_lines;
                    addr_q  <= start_q;
                end
                S_SETUP: begin
                    end_q  <= end_calc;
                    addr_q <= start_q;
                    col_q  <= '0;
                    line_q <= '0;
                end
                S_FETCH: begin
                    if (take) begin
                        if (frame_end) begin
                            mis_q  <= (jump_addr != end_q);
                            addr_q <= start_q;
                            col_q  <= '0;
                            line_q <= '0;
                        end else if (line_end) begin
                            addr_q <= jump_addr;
                            col_q  <= '0;
                            line_q <= line_q + LINE_W'(1);
                        end else begin
                            addr_q <= addr_q + ADDR_W'(1);
                            col_q  <= col_q + WIDTH_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_valid  = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            S_FETCH: req_valid  = 1'b1;
            S_DONE:  frame_done = 1'b1;
            default: ;
        endcase
        req_addr = {bank_q, addr_q};
        end_addr = end_q;
        mismatch = mis_q;
    end

endmodule

// File: rtl/fbaddr_gen.sv
module fbaddr_gen
    import fb_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int BANK_W  = 7,
    parameter int WIDTH_W = 11,
    parameter int LINE_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [ADDR_W-1:0]        cfg_start,
    input  logic [BANK_W-1:0]        cfg_bank,
    input  logic [WIDTH_W-1:0]       cfg_width,
    input  logic [WIDTH_W-1:0]       cfg_skip,
    input  logic [LINE_W-1:0]        cfg_lines,
    input  logic [3:0]               cfg_depth,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [BANK_W+ADDR_W-1:0] req_addr,
    output logic                     frame_done,
    output logic [ADDR_W-1:0]        end_addr,
    output logic                     mismatch,
    output logic [1:0]               pix_per_hw,
    input  logic                     swap_bytes,
    input  logic                     swap_halves,
    input  logic [DATA_W-1:0]        rd_in,
    output logic [DATA_W-1:0]        rd_out
);

    fb_seq #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .WIDTH_W(WIDTH_W),
        .LINE_W (LINE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cfg_start (cfg_start),
        .cfg_bank  (cfg_bank),
        .cfg_width (cfg_width),
        .cfg_skip  (cfg_skip),
        .cfg_lines (cfg_lines),
        .req_ready (req_ready),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .frame_done(frame_done),
        .end_addr  (end_addr),
        .mismatch  (mismatch)
    );

    fb_swap #(
        .DATA_W(DATA_W)
    ) u_swap (
        .swap_bytes (swap_bytes),
        .swap_halves(swap_halves),
        .din        (rd_in),
        .dout       (rd_out)
    );

    assign pix_per_hw = pix_count(cfg_depth);

endmodule

// File: rtl/fbaddr_gen_chk.sv
module fbaddr_gen_chk #(
    parameter int AW = 28,
    parameter int BANK_W = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              req_valid,
    input logic              req_ready,
    input logic [AW-1:0]     req_addr,
    input logic              frame_done,
    input logic              mismatch,
    input logic              swap_bytes,
    input logic              swap_halves,
    input logic [DATA_W-1:0] rd_in,
    input logic [DATA_W-1:0] rd_out
);
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R6

    AST_BANK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |-> req_addr[AW-1 -: BANK_W] == $past(req_addr[AW-1 -: BANK_W])); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !req_valid); // R7

    AST_NO_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !mismatch); // R9

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_bytes && !swap_halves |-> rd_out == rd_in); // R10

    AST_STAY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && $past(!enable) && !req_valid |=> !req_valid); // R13

endmodule

bind fbaddr_gen fbaddr_gen_chk #(
    .AW    (BANK_W + ADDR_W),
    .BANK_W(BANK_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .frame_done (frame_done),
    .mismatch   (mismatch),
    .swap_bytes (swap_bytes),
    .swap_halves(swap_halves),
    .rd_in      (rd_in),
    .rd_out     (rd_out)
);

// File: tb/fbaddr_gen_test.sv
`timescale 1ns/1ps
module fbaddr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [20:0] cfg_start = '0;
    logic [6:0]  cfg_bank = '0;
    logic [10:0] cfg_width = '0;
    logic [10:0] cfg_skip = '0;
    logic [9:0]  cfg_lines = '0;
    logic [3:0]  cfg_depth = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [27:0] req_addr;
    logic        frame_done;
    logic [20:0] end_addr;
    logic        mismatch;
    logic [1:0]  pix_per_hw;
    logic        swap_bytes = 1'b0;
    logic        swap_halves = 1'b0;
    logic [31:0] rd_in = '0;
    logic [31:0] rd_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    fbaddr_gen uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic next_ready();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0] | lfsr[3];
    endfunction

    task automatic run_frame(input logic [20:0] st, input logic [6:0] bk,
                             input int wd, input int sk, input int ln, input bit keep_on);
        int total;
        int idx;
        int wait_n;
        bit stalled;
        logic [63:0] raw;
        logic [20:0] exp_a;
        logic [20:0] exp_end;
        cfg_start = st; cfg_bank = bk;
        cfg_width = 11'(wd); cfg_skip = 11'(sk); cfg_lines = 10'(ln);
        enable = 1'b1;
        total = wd * (ln + 1);
        idx = 0; wait_n = 0; stalled = 1'b0;
        raw = 64'(st) + 64'((wd + sk) * (ln + 1));
        exp_end = raw[20:0];
        while (idx < total && wait_n < 100) begin
            @(negedge clk);
            if (req_valid) begin
                int line = idx / wd;
                int col  = idx % wd;
                raw   = 64'(st) + 64'(line * (wd + sk) + col);
                exp_a = raw[20:0];
                if (idx == 0) begin
                    chk("R8 end address", 64'(end_addr), 64'(exp_end));
                    chk("R2 first address", 64'(req_addr), 64'({bk, st}));
                end else if (stalled)
                    chk("R6 held address", 64'(req_addr), 64'({bk, exp_a}));
                else if (raw[21])
                    chk("R5 wrapped address", 64'(req_addr), 64'({bk, exp_a}));
                else if (col == 0)
                    chk("R4 line skip", 64'(req_addr), 64'({bk, exp_a}));
                else
                    chk("R3 next half-word", 64'(req_addr), 64'({bk, exp_a}));
                req_ready = next_ready();
                stalled = !req_ready;
                if (req_ready) idx++;
                wait_n = 0;
            end else begin
                req_ready = 1'b0;
                wait_n++;
            end
        end
        if (wait_n >= 100) chk("R2 request never seen", 64'(0), 64'(1));
        @(negedge clk);
        req_ready = 1'b0;
        chk("R7 frame_done", 64'(frame_done), 64'(1));
        chk("R7 valid low at done", 64'(req_valid), 64'(0));
        chk("R9 mismatch", 64'(mismatch), 64'(0));
        if (!keep_on) enable = 1'b0;
        @(negedge clk);
        chk("R7 done one cycle", 64'(frame_done), 64'(0));
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid at reset", 64'(req_valid), 64'(0));
        chk("R1 done at reset", 64'(frame_done), 64'(0));
        chk("R1 mismatch at reset", 64'(mismatch), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of small viewports, two start regions
        for (int b = 0; b < 2; b++) begin
            for (int wd = 1; wd <= 3; wd++) begin
                for (int sk = 0; sk <= 2; sk += 2) begin
                    for (int ln = 0; ln <= 2; ln++) begin
                        logic [20:0] st;
                        st = (b == 0) ? 21'h00123 : 21'h1FFFFC;
                        run_frame(st, 7'(7'h55 + wd + ln), wd, sk, ln, 1'b0);
                        repeat (2) @(negedge clk);
                    end
                end
            end
        end

        // R7: back-to-back frames restart from start
        run_frame(21'h1FFFFE, 7'h7F, 2, 3, 1, 1'b1);
        run_frame(21'h1FFFFE, 7'h7F, 2, 3, 1, 1'b0);

        // R13: no request after stop
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R13 stopped", 64'(req_valid), 64'(0));
        end

        // R12: zero width
        cfg_width = '0; cfg_lines = 10'd3; enable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R12 zero width", 64'(req_valid), 64'(0));
        end
        enable = 1'b0;

        // R10: swap combinations
        for (int p = 0; p < 3; p++) begin
            logic [31:0] w;
            w = (p == 0) ? 32'h11223344 : (p == 1) ? 32'hA1B2C3D4 : 32'h00FF807F;
            for (int m = 0; m < 4; m++) begin
                logic [31:0] e;
                rd_in = w; swap_bytes = m[0]; swap_halves = m[1];
                unique case (m)
                    0: e = w;
                    1: e = {w[23:16], w[31:24], w[7:0], w[15:8]};
                    2: e = {w[15:0], w[31:16]};
                    default: e = {w[7:0], w[15:8], w[23:16], w[31:24]};
                endcase
                @(negedge clk);
                chk("R10 swap", 64'(rd_out), 64'(e));
            end
        end
        swap_bytes = 1'b0; swap_halves = 1'b0;

        // R11: every depth code
        for (int c = 0; c < 16; c++) begin
            cfg_depth = 4'(c);
            @(negedge clk);
            chk("R11 depth decode", 64'(pix_per_hw),
                64'((c == 11) ? 2 : (c == 12) ? 1 : 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule